// File: doc/BRIEF.md
# Two-Path Training-Symbol Channel Estimator

This block takes the frequency-domain training symbols of one receive port and finds, for every subcarrier, the complex gains from both transmit ports. Each burst opens with four training slots. In those slots transmit port 1 sends the training value with the sign sequence +,+,−,−. Transmit port 2 sends it with the sign sequence +,−,+,−. The two sign sequences are orthogonal in time. Adding and subtracting the four received samples of a subcarrier therefore separates the two paths. The block multiplies each sample by the known ±1 training value, which replaces a division. It then divides the sum by four, with rounding and saturation, to give 16-bit estimates.

Samples of a slot arrive one subcarrier per accepted cycle, in ascending order. For slots 0 to 2, the running sums of each subcarrier go to an accumulation memory. While slot 3 streams in, each subcarrier's final pair of estimates leaves the block two clock edges after its last sample. One instance serves one receive port; a wider receiver uses one copy per port.

The control is a three-state machine:
- IDLE: after reset, waiting for the first burst.
- TRAIN: accepting training samples.
- DONE: the four slots are complete and samples are ignored.

Transitions:
- IDLE→TRAIN on `burst_start`.
- TRAIN→TRAIN on `burst_start`, which restarts the training.
- TRAIN→DONE when the last subcarrier of slot 3 is accepted.
- DONE→TRAIN on `burst_start`.

Top module: `chest_est`

## Requirements
- R1: After reset, `est_valid` is low. No sample changes anything until the first `burst_start`.
- R2: `burst_start` enters TRAIN and resets the slot and subcarrier counters to zero. Any sample presented in the same cycle is ignored.
- R3: A sample is accepted only in TRAIN, with `sym_valid` and `sym_train` both high. Any other cycle leaves the counters unchanged.
- R4: Within a slot the subcarrier index runs from 0 to NUM_SC−1. After the last subcarrier the slot advances. `est_idx` carries the subcarrier of each estimate.
- R5: With samples r0..r3 in slot order and training value st, `h11 = st·(r0 + r1 − r2 − r3)/4`, computed for real and imaginary parts separately.
- R6: `h12 = st·(r0 − r1 + r2 − r3)/4`, computed for real and imaginary parts separately.
- R7: `ref_neg` = 1 means st = −1, so the sample is negated. `ref_neg` = 0 means st = +1. The value may differ per sample.
- R8: Division by four is (sum + 2) shifted right arithmetically by 2.
- R9: Estimates saturate to the range −32768..32767.
- R10: `est_valid` is high for exactly one cycle per subcarrier. It rises two clock edges after the accepting edge of that subcarrier's slot-3 sample.
- R11: Accepting the last subcarrier of slot 3 enters DONE. Later samples produce no output until the next `burst_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_start | input | 1 | One-cycle pulse opening a burst |
| sym_valid | input | 1 | Sample present this cycle |
| sym_train | input | 1 | Sample belongs to a training slot |
| ref_neg | input | 1 | Training value is −1 for this sample |
| sym_re | input | 16 | Received sample, real part (signed) |
| sym_im | input | 16 | Received sample, imaginary part (signed) |
| est_valid | output | 1 | Estimate pair valid |
| est_idx | output | clog2(NUM_SC) | Subcarrier of the estimate |
| h11_re | output | 16 | Port-1 gain, real part |
| h11_im | output | 16 | Port-1 gain, imaginary part |
| h12_re | output | 16 | Port-2 gain, real part |
| h12_im | output | 16 | Port-2 gain, imaginary part |

## Verification
The assertions assume the following about the inputs:
- `burst_start` is a single-cycle pulse.
- NUM_SC is at least two, so a subcarrier's memory word is never read in the edge that writes it.
- Within a slot, samples arrive in subcarrier order with no other ordering imposed.

The stimulus follows these rules. It pulses `burst_start` for one cycle only and uses six subcarriers. It inserts idle cycles and cycles with `sym_train` low between samples. It includes a restart in the middle of training, and it sends extreme values so that the rounding and saturation edges are reached.

// File: rtl/chest_pkg.sv
package chest_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_DONE  = 2'd2
    } chest_state_e;

    localparam int N_SLOTS = 4;
    localparam int SLOT_W  = $clog2(N_SLOTS);
    localparam int N_ACC   = 4;
endpackage

// File: rtl/chest_slot_ctrl.sv
module chest_slot_ctrl
    import chest_pkg::*;
#(
    parameter int NUM_SC = 1296,
    parameter int SC_W   = $clog2(NUM_SC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic              sym_valid,
    input  logic              sym_train,
    output logic              accept,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SC_W-1:0]   sc_q
);
    localparam logic [SC_W-1:0]   SC_LAST   = SC_W'(NUM_SC - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);

    chest_state_e state_q, state_d;
    logic         last_sc;

    always_comb begin
        accept  = (state_q == ST_TRAIN) && sym_valid && sym_train && !burst_start;
        last_sc = (sc_q == SC_LAST);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (burst_start) state_d = ST_TRAIN;
            ST_TRAIN: if (burst_start) state_d = ST_TRAIN;
                      else if (accept && last_sc && slot_q == SLOT_LAST) state_d = ST_DONE;
            ST_DONE:  if (burst_start) state_d = ST_TRAIN;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
            sc_q   <= '0;
        end else if (burst_start) begin
            slot_q <= '0;
            sc_q   <= '0;
        end else if (accept) begin
            if (last_sc) begin
                sc_q   <= '0;
                slot_q <= slot_q + SLOT_W'(1);
            end else begin
                sc_q   <= sc_q + SC_W'(1);
            end
        end
    end

    AST_BURST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (state_q == ST_TRAIN && slot_q == '0 && sc_q == '0)); // R2
    AST_HOLD_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !burst_start) |=> ($stable(sc_q) && $stable(slot_q))); // R3
    AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_sc && slot_q != SLOT_LAST) |=> (sc_q == '0 && slot_q == $past(slot_q) + SLOT_W'(1))); // R4
    AST_TRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && last_sc && slot_q == SLOT_LAST) |=> (state_q == ST_DONE)); // R11
endmodule

// File: rtl/chest_acc_ram.sv
module chest_acc_ram #(
    parameter int DEPTH  = 1296,
    parameter int WORD_W = 76,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/chest_combine.sv
module chest_combine
    import chest_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = DW + 3
) (
    input  logic [SLOT_W-1:0]     slot,
    input  logic signed [AW-1:0]  x_re,
    input  logic signed [AW-1:0]  x_im,
    input  logic [N_ACC*AW-1:0]   acc_in,
    output logic [N_ACC*AW-1:0]   acc_out,
    output logic signed [DW-1:0]  q11_re,
    output logic signed [DW-1:0]  q11_im,
    output logic signed [DW-1:0]  q12_re,
    output logic signed [DW-1:0]  q12_im
);
    localparam logic signed [AW-1:0] RND = AW'(2);
    localparam logic signed [AW-1:0] HI  = AW'((1 << (DW - 1)) - 1);
    localparam logic signed [AW-1:0] LO  = -HI - AW'(1);

    function automatic logic signed [DW-1:0] rnd_sat(input logic signed [AW-1:0] s);
        logic signed [AW-1:0] t;
        t = (s + RND) >>> 2;
        if (t > HI)      return HI[DW-1:0];
        else if (t < LO) return LO[DW-1:0];
        else             return t[DW-1:0];
    endfunction

    logic signed [AW-1:0] base  [N_ACC];
    logic signed [AW-1:0] term  [N_ACC];
    logic signed [AW-1:0] total [N_ACC];

    // word order: {h11 re, h11 im, h12 re, h12 im}
    always_comb begin
        term[0] = slot[1] ? -x_re : x_re;
        term[1] = slot[1] ? -x_im : x_im;
        term[2] = slot[0] ? -x_re : x_re;
        term[3] = slot[0] ? -x_im : x_im;
    end

    for (genvar k = 0; k < N_ACC; k++) begin : g_acc
        assign base[k]  = (slot == '0) ? '0 : acc_in[(N_ACC-1-k)*AW +: AW];
        assign total[k] = base[k] + term[k];
        assign acc_out[(N_ACC-1-k)*AW +: AW] = total[k];
    end

    assign q11_re = rnd_sat(total[0]);
    assign q11_im = rnd_sat(total[1]);
    assign q12_re = rnd_sat(total[2]);
    assign q12_im = rnd_sat(total[3]);
endmodule

// File: rtl/chest_est.sv
module chest_est
    import chest_pkg::*;
#(
    parameter int NUM_SC = 1296,
    parameter int DW     = 16,
    parameter int SC_W   = $clog2(NUM_SC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 burst_start,
    input  logic                 sym_valid,
    input  logic                 sym_train,
    input  logic                 ref_neg,
    input  logic signed [DW-1:0] sym_re,
    input  logic signed [DW-1:0] sym_im,
    output logic                 est_valid,
    output logic [SC_W-1:0]      est_idx,
    output logic signed [DW-1:0] h11_re,
    output logic signed [DW-1:0] h11_im,
    output logic signed [DW-1:0] h12_re,
    output logic signed [DW-1:0] h12_im
);
    localparam int AW     = DW + 3;
    localparam int WORD_W = N_ACC * AW;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOTS - 1);

    logic              accept;
    logic [SLOT_W-1:0] slot;
    logic [SC_W-1:0]   sc;

    chest_slot_ctrl #(.NUM_SC(NUM_SC), .SC_W(SC_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
        .sym_valid(sym_valid), .sym_train(sym_train),
        .accept(accept), .slot_q(slot), .sc_q(sc)
    );

    logic signed [AW-1:0] ext_re, ext_im;
    assign ext_re = {{(AW-DW){sym_re[DW-1]}}, sym_re};
    assign ext_im = {{(AW-DW){sym_im[DW-1]}}, sym_im};

    logic                 s1_valid;
    logic [SLOT_W-1:0]    s1_slot;
    logic [SC_W-1:0]      s1_idx;
    logic signed [AW-1:0] s1_re, s1_im;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_slot  <= '0;
            s1_idx   <= '0;
            s1_re    <= '0;
            s1_im    <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_slot <= slot;
                s1_idx  <= sc;
                s1_re   <= ref_neg ? -ext_re : ext_re;
                s1_im   <= ref_neg ? -ext_im : ext_im;
            end
        end
    end

    logic [WORD_W-1:0] rd_word, wr_word;
    logic              wr_en;
    assign wr_en = s1_valid && (s1_slot != SLOT_LAST);

    chest_acc_ram #(.DEPTH(NUM_SC), .WORD_W(WORD_W), .ADDR_W(SC_W)) ram_i (
        .clk(clk), .we(wr_en), .waddr(s1_idx), .wdata(wr_word),
        .raddr(sc), .rdata(rd_word)
    );

    logic signed [DW-1:0] c11_re, c11_im, c12_re, c12_im;

    chest_combine #(.DW(DW), .AW(AW)) comb_i (
        .slot(s1_slot), .x_re(s1_re), .x_im(s1_im),
        .acc_in(rd_word), .acc_out(wr_word),
        .q11_re(c11_re), .q11_im(c11_im), .q12_re(c12_re), .q12_im(c12_im)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            est_valid <= 1'b0;
            est_idx   <= '0;
            h11_re    <= '0;
            h11_im    <= '0;
            h12_re    <= '0;
            h12_im    <= '0;
        end else begin
            est_valid <= s1_valid && (s1_slot == SLOT_LAST);
            if (s1_valid && s1_slot == SLOT_LAST) begin
                est_idx <= s1_idx;
                h11_re  <= c11_re;
                h11_im  <= c11_im;
                h12_re  <= c12_re;
                h12_im  <= c12_im;
            end
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && slot == SLOT_LAST) |-> ##2 est_valid); // R10
    AST_OUT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && slot == SLOT_LAST) |-> ##2 (est_idx == $past(sc, 2))); // R4
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept || slot != SLOT_LAST) |-> ##2 !est_valid); // R10
endmodule

// File: tb/chest_est_tb.sv
`timescale 1ns/1ps
module chest_est_tb_top;
    localparam int NSC = 6;
    localparam int SCW = $clog2(NSC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_start = 1'b0, sym_valid = 1'b0, sym_train = 1'b0, ref_neg = 1'b0;
    logic signed [15:0] sym_re = '0, sym_im = '0;
    logic est_valid;
    logic [SCW-1:0] est_idx;
    logic signed [15:0] h11_re, h11_im, h12_re, h12_im;

    always #2 clk = ~clk;

    chest_est #(.NUM_SC(NSC), .DW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start),
        .sym_valid(sym_valid), .sym_train(sym_train), .ref_neg(ref_neg),
        .sym_re(sym_re), .sym_im(sym_im),
        .est_valid(est_valid), .est_idx(est_idx),
        .h11_re(h11_re), .h11_im(h11_im), .h12_re(h12_re), .h12_im(h12_im)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string ctx = "";

    // reference model state
    bit m_act = 0;
    int m_slot = 0, m_sc = 0;
    int acc[NSC][4];
    bit p_v = 0, o_v = 0;
    int p_idx = 0, o_idx = 0;
    int p_h[4], o_h[4];

    // stimulus tables
    int d_re[4][NSC], d_im[4][NSC];
    bit d_n[4][NSC];

    function automatic int rs(int s);
        int t = (s + 2) >>> 2;
        if (t > 32767) return 32767;
        if (t < -32768) return -32768;
        return t;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, ctx, act, exp);
        end
    endtask

    task automatic model_edge(bit bs, bit v, bit t, bit n, int re, int im);
        o_v = p_v; o_idx = p_idx; o_h = p_h;
        p_v = 0;
        if (!rst_n) begin
            o_v = 0; m_act = 0; m_slot = 0; m_sc = 0;
        end else if (bs) begin
            m_act = 1; m_slot = 0; m_sc = 0;
        end else if (m_act && v && t) begin
            int xr = n ? -re : re;
            int xi = n ? -im : im;
            int a = (m_slot >= 2) ? -1 : 1;
            int b = (m_slot % 2 == 1) ? -1 : 1;
            if (m_slot == 0) acc[m_sc] = '{0, 0, 0, 0};
            acc[m_sc][0] += a * xr; acc[m_sc][1] += a * xi;
            acc[m_sc][2] += b * xr; acc[m_sc][3] += b * xi;
            if (m_slot == 3) begin
                p_v = 1; p_idx = m_sc;
                for (int k = 0; k < 4; k++) p_h[k] = rs(acc[m_sc][k]);
            end
            m_sc++;
            if (m_sc == NSC) begin
                m_sc = 0; m_slot++;
                if (m_slot == 4) begin m_slot = 0; m_act = 0; end
            end
        end
    endtask

    task automatic compare();
        chk(est_valid == o_v, "R10 valid", int'(est_valid), int'(o_v));
        if (o_v) begin
            chk(int'(est_idx) == o_idx, "R4 index", int'(est_idx), o_idx);
            chk(int'(h11_re) == o_h[0], "R5 h11_re", int'(h11_re), o_h[0]);
            chk(int'(h11_im) == o_h[1], "R5 h11_im", int'(h11_im), o_h[1]);
            chk(int'(h12_re) == o_h[2], "R6 h12_re", int'(h12_re), o_h[2]);
            chk(int'(h12_im) == o_h[3], "R6 h12_im", int'(h12_im), o_h[3]);
        end
    endtask

    task automatic cyc(bit bs, bit v, bit t, bit n, int re, int im);
        burst_start = bs; sym_valid = v; sym_train = t; ref_neg = n;
        sym_re = 16'(re); sym_im = 16'(im);
        @(posedge clk);
        model_edge(bs, v, t, n, re, im);
        @(negedge clk);
        compare();
    endtask

    function automatic int rnd16();
        return int'($urandom_range(65535)) - 32768;
    endfunction

    task automatic fill_random();
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < NSC; c++) begin
                d_re[s][c] = rnd16(); d_im[s][c] = rnd16();
                d_n[s][c] = 1'($urandom_range(1));
            end
    endtask

    // gaps: insert idle or non-training cycles between samples (R3)
    task automatic send_slots(int first, int last, bit gaps);
        for (int s = first; s <= last; s++)
            for (int c = 0; c < NSC; c++) begin
                if (gaps && $urandom_range(2) == 0) cyc(0, 0, 1, 0, rnd16(), rnd16());
                if (gaps && $urandom_range(2) == 0) cyc(0, 1, 0, 1, rnd16(), rnd16());
                cyc(0, 1, 1, d_n[s][c], d_re[s][c], d_im[s][c]);
            end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        ctx = "R1 reset";
        chk(est_valid == 1'b0, "R1 reset valid", int'(est_valid), 0);
        rst_n = 1'b1;
        // R1: samples before any burst are ignored
        for (int i = 0; i < 10; i++) cyc(0, 1, 1, 0, rnd16(), rnd16());
        chk(est_valid == 1'b0, "R1 idle no output", int'(est_valid), 0);

        // R3, R5, R6, R7: random burst with gaps
        ctx = "R3/R5/R6/R7 random burst";
        fill_random();
        cyc(1, 1, 1, 0, 123, 456);   // R2: same-cycle sample ignored
        send_slots(0, 3, 1);
        idle(3);

        // R11: data and further training after DONE give nothing
        ctx = "R11 after done";
        for (int i = 0; i < 3 * NSC; i++) cyc(0, 1, i % 2, 1'(i % 3), rnd16(), rnd16());
        chk(est_valid == 1'b0, "R11 no output", int'(est_valid), 0);

        // R8 rounding and R9 saturation
        ctx = "R8/R9 directed";
        fill_random();
        for (int s = 0; s < 4; s++) begin
            d_re[s][0] = -32768; d_n[s][0] = (s < 2);     // h11_re sum +131072 -> sat
            d_im[s][0] = -32768; d_n[s][0] = (s < 2);
            d_re[s][1] = 32767;  d_im[s][1] = -32768; d_n[s][1] = 0;
            d_re[s][2] = (s == 0) ? 2 : 0; d_im[s][2] = (s == 0) ? -2 : 0; d_n[s][2] = 0;
            d_re[s][3] = (s == 0) ? 1 : 0; d_im[s][3] = (s == 0) ? -3 : 0; d_n[s][3] = 0;
            d_re[s][4] = (s == 3) ? 6 : 0; d_im[s][4] = (s == 1) ? -6 : 0; d_n[s][4] = 1;
        end
        cyc(1, 0, 0, 0, 0, 0);
        send_slots(0, 3, 0);
        idle(3);

        // R2: restart in the middle of training
        ctx = "R2 restart";
        fill_random();
        cyc(1, 0, 0, 0, 0, 0);
        send_slots(0, 1, 1);
        fill_random();
        cyc(1, 0, 0, 0, 0, 0);
        send_slots(0, 3, 1);
        idle(4);

        // R7: all-negative training value burst
        ctx = "R7 negated";
        fill_random();
        for (int s = 0; s < 4; s++) for (int c = 0; c < NSC; c++) d_n[s][c] = 1;
        cyc(1, 0, 0, 0, 0, 0);
        send_slots(0, 3, 0);
        idle(3);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired [%s] actual=running expected=done", ctx);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule